// File: doc/BRIEF.md
# Page Load Buffer with Inactivity Timeout

This block gathers the data words of one page before a page program operation. Once the command decoder has accepted a program command it pulses `armIn`, which opens a load window. Each word write arrives as two strobes. `wrStartIn` captures the address and `wrEndIn` captures the data. The low address bits pick one of the words in the page, and the words may arrive in any order. The upper address bits form the page address. The first write of the window fixes the page address.

No explicit command closes the window. When no new write starts within a set number of clock cycles after the end of the previous write, the block pulses `doneOut`. At that point the captured page address and a one-bit-per-word loaded mask are ready for the programming engine. The engine reads the words back through a combinational read port. Any word never written reads as all ones, which is the erased pattern. The cycle count stands in for the roughly 100 us hold-off of the physical part.

Top module: `page_load_buffer`

## Requirements
- R1: After reset the window is closed (`loadOpenOut`=0), `doneOut`=0, `maskOut`=0 and `mismatchOut`=0.
- R2: Write strobes while the window is closed store nothing, leave `maskOut` unchanged and produce no `doneOut`.
- R3: An `armIn` pulse while closed opens the window on the next cycle and clears `maskOut` and `mismatchOut`.
- R4: A write stores into word `addrIn[5:0]`. The address is the one present with `wrStartIn`. The data is the one present with `wrEndIn`.
- R5: Words may be written in any order. Each stored word sets bit `addrIn[5:0]` of `maskOut`.
- R6: When the same word is written twice in one window, the later data is kept.
- R7: Reading word `rdOffsetIn` returns the stored data when its mask bit is 1, and all ones (16'hFFFF) otherwise.
- R8: The first write of a window sets `pageOut` = `addrIn[19:6]`. A later write with a different page stores nothing and leaves the mask unchanged, but it still restarts the timeout. It also sets `mismatchOut`, which stays set until the next arm.
- R9: `doneOut` is a one-cycle pulse. It appears exactly `TIMEOUT_CYC` cycles after the clock edge that samples the last `wrEndIn`, and `loadOpenOut` falls at the same time.
- R10: A write start sampled `TIMEOUT_CYC` cycles after the last write end keeps the window open. Before the first write of a window, no timeout runs.
- R11: After `doneOut`, `pageOut`, `maskOut` and the buffer contents hold until the next arm, and further strobes change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| armIn | input | 1 | Program command accepted; opens a window |
| wrStartIn | input | 1 | Start of a word write; address sampled |
| wrEndIn | input | 1 | End of a word write; data sampled |
| addrIn | input | 20 | Word address: page in [19:6], word in [5:0] |
| dataIn | input | 16 | Write data |
| rdOffsetIn | input | 6 | Word index for engine readback |
| loadOpenOut | output | 1 | Load window open |
| doneOut | output | 1 | One-cycle pulse: window closed, buffer handed over |
| pageOut | output | 14 | Captured page address |
| maskOut | output | 64 | Bit per word that was loaded |
| mismatchOut | output | 1 | A write to another page was rejected |
| rdDataOut | output | 16 | Word at `rdOffsetIn`, or all ones when not loaded |

## Verification
The bench places write starts exactly one cycle before the timeout would expire. A design whose counter is off by one would close the window early and report a short mask. It also times each closing pulse against the last data strobe, so a late or doubled pulse shows up as a mismatch against the scoreboard. Two writes are made with different data and addresses at the two strobes. A design that sampled the wrong strobe would store the wrong word or the wrong data. It also rewrites one word, sends a write to a foreign page, and reads all 64 words back. These catch a design that keeps the first data, accepts the foreign write, or returns stale data instead of the erased pattern for unloaded words.

// File: rtl/plb_pkg.sv
package plb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_STROBE = 2'd2,
    ST_GAP    = 2'd3
  } plbState_t;

  typedef struct packed {
    logic clearAll;
    logic latchAddr;
    logic takePage;
    logic commitWord;
    logic flagMismatch;
  } plbStrobe_t;
endpackage

// File: rtl/plb_ctrl.sv
module plb_ctrl
  import plb_pkg::*;
#(
  parameter int TIMEOUT_CYC = 100
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       armIn,
  input  logic       wrStartIn,
  input  logic       wrEndIn,
  input  logic       pageMatchIn,
  output plbStrobe_t strobeOut,
  output logic       loadOpenOut,
  output logic       doneOut
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

  plbState_t stateQ, stateD;
  logic havePageQ;
  logic acceptQ;
  logic [CNT_W-1:0] cntQ;
  logic doneD;
  logic endSeen;

  always_comb begin
    stateD    = stateQ;
    strobeOut = '0;
    doneD     = 1'b0;
    endSeen   = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (armIn) begin
          strobeOut.clearAll = 1'b1;
          stateD = ST_ARMED;
        end
      end
      ST_ARMED, ST_GAP: begin
        if (wrStartIn) begin
          strobeOut.latchAddr = 1'b1;
          if (!havePageQ) strobeOut.takePage = 1'b1;
          else if (!pageMatchIn) strobeOut.flagMismatch = 1'b1;
          stateD = ST_STROBE;
        end else if (stateQ == ST_GAP && cntQ == CNT_LAST) begin
          doneD  = 1'b1;
          stateD = ST_IDLE;
        end
      end
      ST_STROBE: begin
        if (wrEndIn) begin
          endSeen = 1'b1;
          if (acceptQ) strobeOut.commitWord = 1'b1;
          stateD = ST_GAP;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      havePageQ <= 1'b0;
      acceptQ   <= 1'b0;
      cntQ      <= '0;
      doneOut   <= 1'b0;
    end else begin
      stateQ  <= stateD;
      doneOut <= doneD;
      if (strobeOut.clearAll) havePageQ <= 1'b0;
      else if (strobeOut.takePage) havePageQ <= 1'b1;
      if (strobeOut.latchAddr) acceptQ <= !havePageQ || pageMatchIn;
      if (endSeen) cntQ <= '0;
      else if (stateQ == ST_GAP && cntQ != CNT_LAST) cntQ <= cntQ + 1'b1;
    end
  end

  assign loadOpenOut = (stateQ != ST_IDLE);

  // R9: the gap counter never runs past the timeout limit
  p_timer_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= CNT_LAST);

  // R10: no close-out while waiting for the first write
  p_no_early_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_ARMED) |=> !doneOut);
endmodule

// File: rtl/plb_data.sv
module plb_data
  import plb_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 20,
  parameter int OFS_W  = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  plbStrobe_t              strobeIn,
  input  logic [ADDR_W-1:0]       addrIn,
  input  logic [DATA_W-1:0]       dataIn,
  input  logic [OFS_W-1:0]        rdOffsetIn,
  output logic                    pageMatchOut,
  output logic [ADDR_W-OFS_W-1:0] pageOut,
  output logic [(1<<OFS_W)-1:0]   maskOut,
  output logic                    mismatchOut,
  output logic [DATA_W-1:0]       rdDataOut
);
  localparam int WORDS  = 1 << OFS_W;
  localparam int PAGE_W = ADDR_W - OFS_W;

  logic [OFS_W-1:0]  ofsQ;
  logic [PAGE_W-1:0] pageQ;
  logic [WORDS-1:0]  maskQ;
  logic              mismatchQ;
  logic [DATA_W-1:0] memQ [WORDS];

  assign pageMatchOut = (addrIn[ADDR_W-1:OFS_W] == pageQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ofsQ      <= '0;
      pageQ     <= '0;
      maskQ     <= '0;
      mismatchQ <= 1'b0;
    end else begin
      if (strobeIn.latchAddr) ofsQ <= addrIn[OFS_W-1:0];
      if (strobeIn.takePage) pageQ <= addrIn[ADDR_W-1:OFS_W];
      if (strobeIn.clearAll) begin
        maskQ     <= '0;
        mismatchQ <= 1'b0;
      end else begin
        if (strobeIn.commitWord) maskQ[ofsQ] <= 1'b1;
        if (strobeIn.flagMismatch) mismatchQ <= 1'b1;
      end
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : gWord
    always_ff @(posedge clk) begin
      if (strobeIn.commitWord && ofsQ == OFS_W'(w)) memQ[w] <= dataIn;
    end
  end

  assign rdDataOut   = maskQ[rdOffsetIn] ? memQ[rdOffsetIn] : {DATA_W{1'b1}};
  assign pageOut     = pageQ;
  assign maskOut     = maskQ;
  assign mismatchOut = mismatchQ;

  // R8: the page address is fixed once taken, until the next clear
  p_page_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobeIn.takePage |=> $stable(pageQ));

  // R5: at most one new mask bit per cycle
  p_one_word_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobeIn.clearAll |=> $countones(maskQ ^ $past(maskQ)) <= 1);
endmodule

// File: rtl/page_load_buffer.sv
module page_load_buffer
  import plb_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 20,
  parameter int OFS_W       = 6,
  parameter int TIMEOUT_CYC = 100
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    armIn,
  input  logic                    wrStartIn,
  input  logic                    wrEndIn,
  input  logic [ADDR_W-1:0]       addrIn,
  input  logic [DATA_W-1:0]       dataIn,
  input  logic [OFS_W-1:0]        rdOffsetIn,
  output logic                    loadOpenOut,
  output logic                    doneOut,
  output logic [ADDR_W-OFS_W-1:0] pageOut,
  output logic [(1<<OFS_W)-1:0]   maskOut,
  output logic                    mismatchOut,
  output logic [DATA_W-1:0]       rdDataOut
);
  plbStrobe_t strobe;
  logic pageMatch;

  plb_ctrl #(.TIMEOUT_CYC(TIMEOUT_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .armIn(armIn), .wrStartIn(wrStartIn),
    .wrEndIn(wrEndIn), .pageMatchIn(pageMatch), .strobeOut(strobe),
    .loadOpenOut(loadOpenOut), .doneOut(doneOut)
  );

  plb_data #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFS_W(OFS_W)) uData (
    .clk(clk), .rstN(rstN), .strobeIn(strobe), .addrIn(addrIn),
    .dataIn(dataIn), .rdOffsetIn(rdOffsetIn), .pageMatchOut(pageMatch),
    .pageOut(pageOut), .maskOut(maskOut), .mismatchOut(mismatchOut),
    .rdDataOut(rdDataOut)
  );

  // R9: close-out is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  // R9: the window is closed when the pulse is seen
  p_done_closes_r9: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> !loadOpenOut);

  // R2 / R11: nothing is loaded while the window is closed
  p_closed_mask_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!loadOpenOut && !armIn) |=> $stable(maskOut));

  // R8: the mismatch flag is sticky until the next arm
  p_mismatch_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (mismatchOut && !armIn) |=> mismatchOut);
endmodule

// File: tb/sim_page_load_buffer.sv
module sim_page_load_buffer;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 20;
  localparam int OFS_W  = 6;
  localparam int WORDS  = 1 << OFS_W;
  localparam int PAGE_W = ADDR_W - OFS_W;
  localparam int TOUT   = 100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic armIn = 1'b0, wrStartIn = 1'b0, wrEndIn = 1'b0;
  logic [ADDR_W-1:0] addrIn = '0;
  logic [DATA_W-1:0] dataIn = '0;
  logic [OFS_W-1:0]  rdOffsetIn = '0;
  logic loadOpenOut, doneOut, mismatchOut;
  logic [PAGE_W-1:0] pageOut;
  logic [WORDS-1:0]  maskOut;
  logic [DATA_W-1:0] rdDataOut;

  page_load_buffer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFS_W(OFS_W),
                     .TIMEOUT_CYC(TOUT)) u0 (
    .clk(clk), .rstN(rstN), .armIn(armIn), .wrStartIn(wrStartIn),
    .wrEndIn(wrEndIn), .addrIn(addrIn), .dataIn(dataIn),
    .rdOffsetIn(rdOffsetIn), .loadOpenOut(loadOpenOut), .doneOut(doneOut),
    .pageOut(pageOut), .maskOut(maskOut), .mismatchOut(mismatchOut),
    .rdDataOut(rdDataOut)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycle = 0;
  int lastEnd = 0;
  always @(posedge clk) cycle <= cycle + 1;

  // reference model
  logic              armedM = 1'b0, haveM = 1'b0, mismM = 1'b0;
  logic [PAGE_W-1:0] pageM = '0;
  logic [WORDS-1:0]  maskM = '0;
  logic [DATA_W-1:0] memM [WORDS];
  logic [PAGE_W+WORDS-1:0] expQ[$];

  task automatic checkVal(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic armWindow();
    armIn = 1'b1;
    @(negedge clk);
    armIn = 1'b0;
    armedM = 1'b1; haveM = 1'b0; mismM = 1'b0; maskM = '0;
    @(negedge clk);
  endtask

  task automatic writeWord(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    logic [OFS_W-1:0] ofs;
    ofs = a[OFS_W-1:0];
    wrStartIn = 1'b1; addrIn = a; dataIn = ~d;
    @(negedge clk);
    wrStartIn = 1'b0; addrIn = ~a; dataIn = d; wrEndIn = 1'b1;
    @(negedge clk);
    wrEndIn = 1'b0; dataIn = 16'h1234;
    lastEnd = cycle;
    if (armedM) begin
      if (!haveM) begin
        haveM = 1'b1; pageM = a[ADDR_W-1:OFS_W];
      end
      if (a[ADDR_W-1:OFS_W] == pageM) begin
        maskM[ofs] = 1'b1; memM[ofs] = d;
      end else mismM = 1'b1;
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishLoad();
    expQ.push_back({pageM, maskM});
    for (int i = 0; i < 3 * TOUT && expQ.size() != 0; i++) @(negedge clk);
    if (expQ.size() != 0) begin
      checks++; errors++;
      $display("FAIL R9: actual no done pulse expected done");
      expQ.delete();
    end
    armedM = 1'b0;
  endtask

  task automatic readAll(string tag);
    for (int w = 0; w < WORDS; w++) begin
      rdOffsetIn = OFS_W'(w);
      #1;
      checkVal(tag, 64'(rdDataOut), maskM[w] ? 64'(memM[w]) : 64'hFFFF);
    end
  endtask

  // monitor: pops expected close-out items as the design produces them
  always @(negedge clk) begin
    if (rstN && doneOut) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9: actual unexpected done expected none");
      end else begin
        logic [PAGE_W+WORDS-1:0] e;
        e = expQ.pop_front();
        checkVal("R8 page at done", 64'(pageOut), 64'(e[PAGE_W+WORDS-1:WORDS]));
        checkVal("R5 mask at done", maskOut, e[WORDS-1:0]);
        checkVal("R9 done latency", 64'(cycle - lastEnd), 64'(TOUT));
        checkVal("R9 window closed", 64'(loadOpenOut), 64'd0);
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  localparam logic [PAGE_W-1:0] P1 = 14'h0ABC;
  localparam logic [PAGE_W-1:0] P2 = 14'h1234;

  initial begin
    logic [WORDS-1:0] maskSnap;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    checkVal("R1 open", 64'(loadOpenOut), 0);
    checkVal("R1 done", 64'(doneOut), 0);
    checkVal("R1 mask", maskOut, 0);
    checkVal("R1 mismatch", 64'(mismatchOut), 0);

    // R2: strobes before arm
    writeWord({P1, 6'd3}, 16'hAAAA);
    idle(TOUT + 5);
    checkVal("R2 mask closed", maskOut, 0);
    checkVal("R2 still closed", 64'(loadOpenOut), 0);

    // R3 / R10: arm, no timer before first write
    armWindow();
    checkVal("R3 open", 64'(loadOpenOut), 1);
    checkVal("R3 mask cleared", maskOut, 0);
    idle(3 * TOUT);
    checkVal("R10 open without writes", 64'(loadOpenOut), 1);

    // R4 R5 R6 R10: out of order, boundary gaps
    writeWord({P1, 6'd5}, 16'h0505);
    idle(TOUT - 1);
    writeWord({P1, 6'd63}, 16'h6363);
    idle(TOUT - 1);
    writeWord({P1, 6'd0}, 16'h0000);
    idle(TOUT - 1);
    checkVal("R10 open at boundary", 64'(loadOpenOut), 1);
    writeWord({P1, 6'd17}, 16'h1717);
    writeWord({P1, 6'd5}, 16'h5A5A);
    checkVal("R5 mask during load", maskOut, maskM);
    // R8: foreign page
    maskSnap = maskOut;
    writeWord({P2, 6'd9}, 16'hDEAD);
    checkVal("R8 mismatch set", 64'(mismatchOut), 1);
    checkVal("R8 mask unchanged", maskOut, maskSnap);
    idle(TOUT - 1);
    writeWord({P1, 6'd40}, 16'h4040);
    checkVal("R8 mismatch sticky", 64'(mismatchOut), 1);
    finishLoad();
    readAll("R7 R4 R6 readback");

    // R11: strobes after close-out
    maskSnap = maskOut;
    writeWord({P2, 6'd1}, 16'hBEEF);
    idle(TOUT + 5);
    checkVal("R11 mask held", maskOut, maskSnap);
    checkVal("R11 page held", 64'(pageOut), 64'(P1));
    readAll("R11 buffer held");

    // R3: re-arm clears mismatch and mask; single word window
    armWindow();
    checkVal("R3 mismatch cleared", 64'(mismatchOut), 0);
    checkVal("R3 mask cleared again", maskOut, 0);
    writeWord({P2, 6'd62}, 16'hC0DE);
    finishLoad();
    checkVal("R8 new page", 64'(pageOut), 64'(P2));
    readAll("R7 erased words");

    idle(5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule